// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, for each incoming Ethernet frame, whether the frame is kept or dropped, using only its 48-bit destination address. A parser upstream presents the address in parallel with a one-cycle valid strobe. Two clock edges later the block returns an accept flag and a reason code.

Software programs the block through a small write port. It sets a station address for exact unicast matching and a 64-bin multicast hash table held in two 32-bit words. It also sets four enables: unicast match, multicast hash, broadcast and promiscuous. The multicast bin is chosen by the top six bits of a CRC-32 over the six address bytes. The CRC is computed MSB-first in the register, starts from all ones, takes each byte least significant bit first, and is not inverted. Strobes may arrive on every cycle.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, every configuration word is zero, `dec_valid` is low, and every address is rejected with reason 0.
- R2: Each `da_valid` strobe sampled on a clock edge produces exactly one `dec_valid` pulse, visible after the second following edge. Back-to-back strobes produce back-to-back results in order.
- R3: When the promiscuous enable (control bit 3) is set, every address is accepted with reason 1, overriding all other checks.
- R4: An all-ones address is accepted with reason 2 only when the broadcast enable (control bit 2) is set. Otherwise it is rejected, whatever the hash table holds.
- R5: An address whose bit 40 (the group bit of the first byte, `da[47:40]`) is clear is accepted with reason 3 when the unicast enable (control bit 0) is set and it equals the station address. Word 1 holds bytes 0,1,2 at bits 23:16, 15:8 and 7:0, and word 2 holds bytes 3,4,5 the same way.
- R6: A unicast address that differs from the station address, or any unicast address while control bit 0 is clear, is rejected with reason 0.
- R7: A non-broadcast group address is accepted with reason 4 when the multicast enable (control bit 1) is set and its hash bin is set. The bin is CRC[31:26] of the address bytes 0..5. Bin bit 5 selects word 4 (bit 5 set) or word 3 (bit 5 clear), and bin bits 4:0 select the bit within that word.
- R8: With control bit 1 clear, a group address other than broadcast is rejected with reason 0 even when its hash bin is set.
- R9: With both hash words all ones and control bit 1 set, every non-broadcast group address is accepted with reason 4.
- R10: Writes to word addresses 5, 6 and 7 change no behaviour. Word 0 is control: bit 0 unicast, bit 1 multicast, bit 2 broadcast, bit 3 promiscuous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address valid strobe |
| da | input | 48 | Destination address, byte 0 in bits 47:40 |
| dec_valid | output | 1 | Decision valid |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | 0 reject, 1 promiscuous, 2 broadcast, 3 unicast, 4 multicast |

## Verification
The bench keeps its own bit-serial CRC model and a mirror of the written configuration, and it predicts every decision independently of the design. It targets several corner cases, each tied to a specific error:
- Broadcast with the hash table full but the broadcast enable off. A design that lets the multicast path catch broadcast accepts it here.
- A group address whose bin lands in the upper hash word. Reversed byte or bit order in the CRC, or a swapped word select, picks the wrong bin.
- A unicast address differing from the station address only in its last byte. A truncated compare accepts it.
- Writes to the unused word addresses. An address decoder that aliases them corrupts the station address or the enables.

A continuous stream of strobes checks that results keep their order and the fixed two-edge latency.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ADDR_W = 48,
  parameter int CFG_AW = 3,
  parameter int CFG_DW = 32,
  parameter int BIN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              da_valid,
  input  logic [ADDR_W-1:0] da,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [2:0]        dec_reason
);
  localparam int NBYTES = ADDR_W / 8;
  localparam int HALF   = ADDR_W / 2;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  localparam logic [2:0] RSN_REJ = 3'd0;
  localparam logic [2:0] RSN_PRM = 3'd1;
  localparam logic [2:0] RSN_BC  = 3'd2;
  localparam logic [2:0] RSN_UC  = 3'd3;
  localparam logic [2:0] RSN_MC  = 3'd4;

  logic [3:0]        ctrl;
  logic [HALF-1:0]   sta_hi, sta_lo;
  logic [31:0]       hash0, hash1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      sta_hi <= '0;
      sta_lo <= '0;
      hash0  <= '0;
      hash1  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: ctrl   <= cfg_wdata[3:0];
        3'd1: sta_hi <= cfg_wdata[HALF-1:0];
        3'd2: sta_lo <= cfg_wdata[HALF-1:0];
        3'd3: hash0  <= cfg_wdata;
        3'd4: hash1  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  wire uc_en = ctrl[0];
  wire mc_en = ctrl[1];
  wire bc_en = ctrl[2];
  wire pr_en = ctrl[3];

  function automatic logic [31:0] crc_be(input logic [ADDR_W-1:0] a);
    logic [31:0] c;
    logic        fb;
    c = '1;
    for (int b = 0; b < NBYTES; b++)
      for (int i = 0; i < 8; i++) begin
        fb = c[31] ^ a[ADDR_W-8-8*b+i];
        c  = {c[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
      end
    return c;
  endfunction

  logic              s1_v;
  logic [ADDR_W-1:0] s1_da;
  logic [BIN_W-1:0]  s1_bin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_da  <= '0;
      s1_bin <= '0;
    end else begin
      s1_v <= da_valid;
      if (da_valid) begin
        s1_da  <= da;
        s1_bin <= crc_be(da)[31 -: BIN_W];
      end
    end
  end

  wire is_bc   = &s1_da;
  wire is_grp  = s1_da[ADDR_W-8];
  wire uc_hit  = (s1_da == {sta_hi, sta_lo});
  wire bin_set = s1_bin[BIN_W-1] ? hash1[s1_bin[BIN_W-2:0]] : hash0[s1_bin[BIN_W-2:0]];

  logic [2:0] rsn_c;
  always_comb begin
    if (pr_en)                            rsn_c = RSN_PRM;
    else if (is_bc)                       rsn_c = bc_en ? RSN_BC : RSN_REJ;
    else if (is_grp)                      rsn_c = (mc_en && bin_set) ? RSN_MC : RSN_REJ;
    else                                  rsn_c = (uc_en && uc_hit) ? RSN_UC : RSN_REJ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_reason <= RSN_REJ;
    end else begin
      dec_valid  <= s1_v;
      dec_accept <= s1_v && (rsn_c != RSN_REJ);
      dec_reason <= s1_v ? rsn_c : RSN_REJ;
    end
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> ##1 dec_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(da_valid, 2));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && dec_reason == RSN_REJ));
  a_r3_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && pr_en && $stable(ctrl)) |-> (dec_accept && dec_reason == RSN_PRM));
  a_r4_bcast_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_reason == RSN_BC) |-> $past(bc_en));
  a_r8_mcast_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_reason == RSN_MC) |-> $past(mc_en));
endmodule

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        da_valid = 0;
  logic [47:0] da = '0;
  logic        dec_valid, dec_accept;
  logic [2:0]  dec_reason;

  rx_addr_filter dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [3:0]  m_ctrl = '0;
  logic [47:0] m_sta = '0;
  logic [31:0] m_h0 = '0, m_h1 = '0;

  logic        q_acc[$];
  logic [2:0]  q_rsn[$];
  int          q_cyc[$];
  string       q_tag[$];

  function automatic logic [5:0] ref_bin(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] byt = a[47-8*b -: 8];
      for (int i = 0; i < 8; i++) begin
        logic top = c[31];
        c = c << 1;
        if (top != byt[i]) c = c ^ 32'h04C11DB7;
      end
    end
    return c[31:26];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    case (a)
      3'd0: m_ctrl = d[3:0];
      3'd1: m_sta[47:24] = d[23:0];
      3'd2: m_sta[23:0] = d[23:0];
      3'd3: m_h0 = d;
      3'd4: m_h1 = d;
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input string tag, input logic [47:0] a, input logic keep_going = 0);
    logic [2:0] r;
    logic [5:0] bn;
    logic hb;
    bn = ref_bin(a);
    hb = bn[5] ? m_h1[bn[4:0]] : m_h0[bn[4:0]];
    if (m_ctrl[3]) r = 3'd1;
    else if (a == 48'hFFFF_FFFF_FFFF) r = m_ctrl[2] ? 3'd2 : 3'd0;
    else if (a[40]) r = (m_ctrl[1] && hb) ? 3'd4 : 3'd0;
    else r = (m_ctrl[0] && a == m_sta) ? 3'd3 : 3'd0;
    if (!keep_going) @(negedge clk);
    da_valid = 1; da = a;
    q_acc.push_back(r != 0); q_rsn.push_back(r);
    q_cyc.push_back(cyc + 1); q_tag.push_back(tag);
    @(negedge clk);
    da_valid = 0;
  endtask

  task automatic drain();
    int n = 0;
    while (q_acc.size() != 0 && n < 50) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      if (q_acc.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected result actual=1 expected=0");
      end else begin
        string t = q_tag.pop_front();
        chk({t, " accept"}, dec_accept, q_acc.pop_front());
        chk({t, " reason"}, dec_reason, q_rsn.pop_front());
        chk("R2 latency", cyc, q_cyc.pop_front() + 1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] ma, mb;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", dec_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid after reset", dec_valid, 0);
    send("R1 bcast", 48'hFFFF_FFFF_FFFF);
    send("R1 unicast zero", 48'h0);
    send("R1 group", 48'h0100_5E00_0001);
    drain();

    wr(3'd1, 32'h0002_A1B2); wr(3'd2, 32'h00C3_D4E5);
    wr(3'd0, 32'h1);
    send("R5 match", 48'h02A1_B2C3_D4E5);
    send("R6 last byte", 48'h02A1_B2C3_D4E4);
    send("R6 first byte", 48'h04A1_B2C3_D4E5);
    drain();
    wr(3'd0, 32'h0);
    send("R6 disabled", 48'h02A1_B2C3_D4E5);
    drain();

    wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd0, 32'h2);
    send("R4 bcast off", 48'hFFFF_FFFF_FFFF);
    send("R9 group a", 48'h0100_5E7F_FFFA);
    send("R9 group b", 48'h3333_0000_0001);
    drain();
    wr(3'd0, 32'h6);
    send("R4 bcast on", 48'hFFFF_FFFF_FFFF);
    drain();
    wr(3'd0, 32'h5);
    send("R8 mc off", 48'h0100_5E00_00FB);
    drain();

    ma = 48'h0100_5E00_0001;
    mb = 48'h0100_5E00_0001;
    for (int k = 0; k < 64; k++) begin
      mb = 48'h0100_5E00_0000 + 48'(k);
      if (ref_bin(ma)[5] == 1'b0 && ref_bin(mb)[5] == 1'b1) break;
      if (ref_bin(ma)[5] == 1'b1) ma = mb;
    end
    wr(3'd3, 32'h0); wr(3'd4, 32'h0);
    wr(3'd0, 32'h2);
    if (ref_bin(mb)[5]) wr(3'd4, 32'h1 << ref_bin(mb)[4:0]);
    else wr(3'd3, 32'h1 << ref_bin(mb)[4:0]);
    send("R7 bin set", mb);
    send("R7 bin clear", ma);
    send("R7 neighbour", mb ^ 48'h0000_0000_0100);
    drain();

    wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
    send("R10 bcast", 48'hFFFF_FFFF_FFFF);
    send("R10 station", 48'h02A1_B2C3_D4E5);
    send("R10 bin", mb);
    drain();

    wr(3'd0, 32'h8);
    send("R3 bcast", 48'hFFFF_FFFF_FFFF);
    send("R3 unicast", 48'h1234_5678_9ABC);
    send("R3 group", ma);
    drain();

    wr(3'd0, 32'h7);
    @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      case (k % 4)
        0: send("R2 stream uc", 48'h02A1_B2C3_D4E5, 1);
        1: send("R2 stream bc", 48'hFFFF_FFFF_FFFF, 1);
        2: send("R2 stream mc", mb, 1);
        default: send("R2 stream miss", 48'h0600_0000_0000 + 48'(k), 1);
      endcase
      if (k != 19) begin
        da_valid = 1;
        da = da;
      end
    end
    da_valid = 0;
    drain();
    chk("R2 queue empty", q_acc.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule